// File: doc/BRIEF.md
# Sequenced Palette Colour Loader

This block holds a colour lookup table of 256 entries, each a red, green and blue byte, and lets a bus master fill it through a small register window of two 32-bit words. One word selects the entry to load. The other word is written three times in a row. The writes carry red, then green, then blue. Each colour byte comes from the top byte of the written word. After the blue byte, the selected entry moves on by one, so a whole table can be streamed after a single index write.

A second, independent port serves the pixel path. It takes an entry number and returns that entry's 24-bit colour one clock later. Every component write lands in the table at once, so a reader can see an entry that is only partly loaded. Reset puts the table in a known state: black everywhere except the last entry, which is white.

Top module: `pal_dac_port`

## Requirements
- R1: A write with byte offset 0 loads the entry pointer from wr_data[31:24] and returns the component step to red.
- R2: Successive writes with byte offset 4 store wr_data[31:24] into the red, green and blue component of the pointed-to entry, in that order.
- R3: The blue write advances the pointer by one modulo 256 (255 wraps to 0) and returns the step to red.
- R4: rd_data is always zero.
- R5: A write with any byte offset other than 0 or 4 changes neither the table, the pointer nor the component step.
- R6: A write whose wr_be is not 4'b1111 changes neither the table, the pointer nor the component step.
- R7: After reset, entries 0 to 254 read 24'h000000 and entry 255 reads 24'hFFFFFF. The pointer is 0 and the step is red.
- R8: Each component write is visible on the read port by itself, before the rest of the entry is loaded.
- R9: pix_rgb carries the colour of the entry presented on pix_idx at the previous clock edge, packed as {red[23:16], green[15:8], blue[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset within the 16-byte window |
| wr_data | input | 32 | Write data; colour and index taken from bits 31:24 |
| wr_be | input | 4 | Byte enables; only all-ones is accepted |
| rd_data | output | 32 | Register read data (always zero) |
| pix_idx | input | 8 | Entry number for the pixel read port |
| pix_rgb | output | 24 | Colour of the entry, one cycle after pix_idx |

## Verification
A wrong component step shows up on the very next data write: the byte lands in the wrong colour lane of the entry. The bench sees this on its next read of that entry, one cycle after it presents the entry number. A wrong pointer puts bytes into a neighbouring entry, and a missed advance leaves the entry's earlier colours overwritten. The random stream mixes rejected accesses between data writes, so an illegal access that moves the step or the pointer corrupts a later entry. A full scan of the table after reset and at the end exposes any stray write.

// File: rtl/pal_pkg.sv
package pal_pkg;
   typedef enum logic [1:0] {
      STEP_RED   = 2'd0,
      STEP_GREEN = 2'd1,
      STEP_BLUE  = 2'd2
   } step_t;

   localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_seq_ctrl.sv
module pal_seq_ctrl
   import pal_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int PTR_OFF  = 0,
   parameter int DATA_OFF = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_be,
   output logic [NUM_COMP-1:0] comp_we,
   output logic [IDX_W-1:0]    wr_ptr,
   output logic [COMP_W-1:0]   comp_val
);
   localparam int BE_W = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (IDX_W > DATA_W || COMP_W > DATA_W) begin : g_bad_field
         $error("index and component fields must fit in the data word");
      end
   endgenerate

   step_t            step_q;
   logic [IDX_W-1:0] ptr_q;
   logic             full_be;
   logic             hit_ptr;
   logic             hit_data;

   assign full_be  = (wr_be == {BE_W{1'b1}});
   assign hit_ptr  = wr_en && full_be && (wr_addr == ADDR_W'(PTR_OFF));
   assign hit_data = wr_en && full_be && (wr_addr == ADDR_W'(DATA_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= STEP_RED;
         ptr_q  <= '0;
      end else if (hit_ptr) begin
         step_q <= STEP_RED;
         ptr_q  <= wr_data[DATA_W-1 -: IDX_W];
      end else if (hit_data) begin
         unique case (step_q)
            STEP_RED:   step_q <= STEP_GREEN;
            STEP_GREEN: step_q <= STEP_BLUE;
            default: begin
               step_q <= STEP_RED;
               ptr_q  <= ptr_q + 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      comp_we = '0;
      if (hit_data) begin
         comp_we[step_q] = 1'b1;
      end
   end

   assign wr_ptr   = ptr_q;
   assign comp_val = wr_data[DATA_W-1 -: COMP_W];

   // R1
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ptr |=> (ptr_q == $past(wr_data[DATA_W-1 -: IDX_W])) && (step_q == STEP_RED));

   // R2
   step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_data && step_q == STEP_RED) |=> (step_q == STEP_GREEN) && $stable(ptr_q));

   // R3
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_data && step_q == STEP_BLUE) |=> (ptr_q == $past(ptr_q) + 1'b1) && (step_q == STEP_RED));

   // R6
   partial_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full_be) |=> $stable(ptr_q) && $stable(step_q));

   // R5
   bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != ADDR_W'(PTR_OFF) && wr_addr != ADDR_W'(DATA_OFF))
      |=> $stable(ptr_q) && $stable(step_q));
endmodule

// File: rtl/pal_store.sv
module pal_store
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_COMP-1:0]        comp_we,
   input  logic [IDX_W-1:0]           wr_ptr,
   input  logic [COMP_W-1:0]          comp_val,
   input  logic [IDX_W-1:0]           pix_idx,
   output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
         $error("IDX_W out of supported range");
      end
   endgenerate

   genvar c;
   generate
      for (c = 0; c < NUM_COMP; c++) begin : g_plane
         logic [COMP_W-1:0] plane [DEPTH];
         logic [COMP_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int e = 0; e < DEPTH; e++) begin
                  plane[e] <= (e == DEPTH - 1) ? {COMP_W{1'b1}} : '0;
               end
               rd_q <= '0;
            end else begin
               if (comp_we[c]) begin
                  plane[wr_ptr] <= comp_val;
               end
               rd_q <= plane[pix_idx];
            end
         end

         assign pix_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] = rd_q;
      end
   endgenerate

   // R2
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(comp_we));
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
   import pal_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [DATA_W/8-1:0]        wr_be,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [IDX_W-1:0]           pix_idx,
   output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);
   logic [NUM_COMP-1:0] comp_we;
   logic [IDX_W-1:0]    wr_ptr;
   logic [COMP_W-1:0]   comp_val;

   pal_seq_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .COMP_W(COMP_W),
      .PTR_OFF(0), .DATA_OFF(4)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .comp_we(comp_we),
      .wr_ptr(wr_ptr), .comp_val(comp_val)
   );

   pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
      .clk(clk), .rst_n(rst_n), .comp_we(comp_we), .wr_ptr(wr_ptr),
      .comp_val(comp_val), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   assign rd_data = '0;
endmodule

// File: tb/tb_pal_dac_port.sv
module tb_pal_dac_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] rd_data;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [23:0] m_tab [256];
   logic [7:0]  m_ptr;
   int          m_step;

   always #10 clk = ~clk;

   pal_dac_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   function automatic logic [23:0] put_lane(logic [23:0] old, int step, logic [7:0] v);
      logic [23:0] r = old;
      r[(2-step)*8 +: 8] = v;
      return r;
   endfunction

   task automatic model_reset();
      for (int e = 0; e < 256; e++) m_tab[e] = (e == 255) ? 24'hFFFFFF : 24'h0;
      m_ptr = 0;
      m_step = 0;
   endtask

   task automatic bus_write(logic [3:0] a, logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0;
      if (be == 4'hF && a == 4'd0) begin
         m_ptr = d[31:24];
         m_step = 0;
      end else if (be == 4'hF && a == 4'd4) begin
         m_tab[m_ptr] = put_lane(m_tab[m_ptr], m_step, d[31:24]);
         if (m_step == 2) begin
            m_step = 0;
            m_ptr = m_ptr + 8'd1;
         end else begin
            m_step = m_step + 1;
         end
      end
   endtask

   task automatic check_entry(logic [7:0] e, string tag);
      @(negedge clk);
      pix_idx = e;
      @(negedge clk);
      checks++;
      if (pix_rgb !== m_tab[e]) begin
         fails++;
         $display("FAIL %s entry %0d: actual %h expected %h", tag, e, pix_rgb, m_tab[e]);
      end
   endtask

   task automatic check_rd(string tag);
      checks++;
      if (rd_data !== 32'h0) begin
         fails++;
         $display("FAIL %s rd_data: actual %h expected 0", tag, rd_data);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_1234);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R7 reset contents, all entries
      for (int e = 0; e < 256; e++) check_entry(8'(e), "R7");
      // R4
      check_rd("R4");

      // R7 pointer 0 and step red after reset: first data write goes to red of entry 0
      bus_write(4'd4, 32'hA1000000, 4'hF);
      check_entry(8'd0, "R7");
      // R8 partial entry visible
      check_entry(8'd0, "R8");
      bus_write(4'd4, 32'hB2000000, 4'hF);
      check_entry(8'd0, "R8");
      bus_write(4'd4, 32'hC3000000, 4'hF);
      // R2 full order
      check_entry(8'd0, "R2");
      // R3 pointer advanced to 1
      bus_write(4'd4, 32'h11000000, 4'hF);
      check_entry(8'd1, "R3");

      // R1 index write mid-sequence restarts at red
      bus_write(4'd0, 32'h40FFFFFF, 4'hF);
      bus_write(4'd4, 32'h55000000, 4'hF);
      check_entry(8'h40, "R1");

      // R3 wrap from 255 to 0
      bus_write(4'd0, 32'hFF000000, 4'hF);
      bus_write(4'd4, 32'h01000000, 4'hF);
      bus_write(4'd4, 32'h02000000, 4'hF);
      bus_write(4'd4, 32'h03000000, 4'hF);
      bus_write(4'd4, 32'h77000000, 4'hF);
      check_entry(8'hFF, "R3");
      check_entry(8'h00, "R3");

      // R5 other offsets ignored
      bus_write(4'd0, 32'h20000000, 4'hF);
      bus_write(4'd8, 32'h99000000, 4'hF);
      bus_write(4'd12, 32'h21000000, 4'hF);
      bus_write(4'd5, 32'h98000000, 4'hF);
      bus_write(4'd4, 32'h66000000, 4'hF);
      check_entry(8'h20, "R5");
      check_entry(8'h21, "R5");

      // R6 partial byte enables ignored
      bus_write(4'd4, 32'h88000000, 4'h8);
      bus_write(4'd0, 32'h30000000, 4'h7);
      bus_write(4'd4, 32'h44000000, 4'hF);
      check_entry(8'h20, "R6");
      check_entry(8'h30, "R6");

      // Random stream mixing legal and illegal accesses
      for (int n = 0; n < 600; n++) begin
         int kind;
         logic [3:0] a;
         logic [3:0] be;
         kind = int'($urandom_range(0, 9));
         a  = (kind < 1) ? 4'd0 : (kind < 7) ? 4'd4 : 4'($urandom_range(0, 15));
         be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
         bus_write(a, $urandom, be);
         if (n % 8 == 7) begin
            check_entry(m_ptr, "R2");
            check_entry(8'($urandom_range(0, 255)), "R9");
            check_rd("R4");
         end
      end

      // R9 back-to-back index changes, one-cycle latency per entry
      for (int e = 0; e < 256; e++) check_entry(8'(e), "R9");

      done = 1'b1;
      finish_run();
   end
endmodule